// File: doc/BRIEF.md
# Indirect Byte-Memory Access Window with Region Locks

This block puts a byte-wide memory of a few kilobytes behind a narrow four-offset I/O window. Software first loads a 16-bit address pointer, one byte at a time, through two offsets. It then moves one data byte through a third offset. Every data write clears the pointer back to zero. A data read leaves the pointer where it is, so the same location can be polled repeatedly.

The pointer space has three parts. The lower part is plain storage, held in an inferred block RAM inside the block. The top few addresses below the memory size belong to a clock-register bank that lives outside the block; accesses to them are passed on through a strobed side port. Anything at or above the memory size is void. Two fixed 16-byte windows in plain storage can be sealed, each by its own lock bit. A sealed window ignores writes and reads back as all ones. Lock bits are raised through a dedicated input and drop only on reset.

Top module: `nvram_port`

## Requirements
- R1: Reset (synchronous, active high) sets the pointer to 0x0000, clears both lock bits, drives bus_rvalid, reg_wr and reg_rd low and sets bus_rdata to 0xFF.
- R2: A write at offset 0 replaces pointer bits 7:0 with the data byte, and a write at offset 1 replaces pointer bits 15:8; the other half is kept.
- R3: A write at offset 3 to a plain-storage address stores the data byte there, and the pointer reads as 0x0000 in the next cycle whatever region was addressed.
- R4: A read at offset 3 of a plain-storage address returns the stored byte on bus_rdata with bus_rvalid high exactly two cycles after the request edge, and it leaves the pointer unchanged. Each read gives exactly one bus_rvalid pulse.
- R5: A read at offset 0, 1 or 2 returns 0xFF with the same two-cycle timing.
- R6: A write at offset 2 changes neither the pointer nor any memory byte.
- R7: With lock bit 0 set, addresses 0x0020..0x002F ignore writes and read as 0xFF. Lock bit 1 does the same for 0x0030..0x003F. Addresses outside a sealed window are unaffected.
- R8: A high bit on lock_set raises the matching lock bit from the next cycle. The bit stays set until reset, and stored bytes survive the reset.
- R9: A pointer at or above MEM_BYTES reads as 0xFF. A write there changes no stored byte, and in particular does not alias into low addresses.
- R10: Addresses from CLK_BASE up to MEM_BYTES-1 go to the side port. reg_wr or reg_rd pulses for one cycle, one cycle after the request, with reg_addr = pointer - CLK_BASE and reg_wdata carrying the byte. The reg_rdata value present during that pulse is returned on bus_rdata one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_off | input | 2 | Window offset: 0 pointer low, 1 pointer high, 3 data |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, registered |
| bus_rvalid | output | 1 | bus_rdata holds a read result |
| lock_set | input | NUM_LOCKS | Per-window lock raise |
| reg_wr | output | 1 | Side-port write strobe |
| reg_rd | output | 1 | Side-port read strobe |
| reg_addr | output | REG_AW | Offset within the clock-register bank |
| reg_wdata | output | 8 | Side-port write byte |
| reg_rdata | input | 8 | Side-port read byte, sampled while reg_rd is high |

## Verification
Pointer updates, side-port strobes and lock changes show up one cycle after the request edge. Read data and bus_rvalid show up two cycles after it. The bench's reference model stores each expectation under the cycle number in which it is due. It compares bus_rvalid, bus_rdata, reg_wr, reg_rd, reg_addr and reg_wdata on every falling edge. An output that is high in a cycle with no expectation counts as a mismatch, as does one that stays low when a value is due. Stimulus is driven on the falling edge, so each request is taken at the next rising edge and the due cycle follows from that.

// File: rtl/nvram_port_pkg.sv
package nvram_port_pkg;
  typedef enum logic [1:0] {
    RGN_RAM     = 2'd0,
    RGN_CLK     = 2'd1,
    RGN_BLOCKED = 2'd2,
    RGN_VOID    = 2'd3
  } region_e;

  localparam logic [1:0] OFF_PTR_LO = 2'd0;
  localparam logic [1:0] OFF_PTR_HI = 2'd1;
  localparam logic [1:0] OFF_DATA   = 2'd3;
endpackage

// File: rtl/nvram_port_decode.sv
module nvram_port_decode
  import nvram_port_pkg::*;
#(
  parameter int PTR_W     = 16,
  parameter int MEM_BYTES = 2048,
  parameter int CLK_BASE  = 2040,
  parameter int NUM_LOCKS = 2,
  parameter int LOCK_BASE = 32,
  parameter int LOCK_SPAN = 16
) (
  input  logic [PTR_W-1:0]     addr,
  input  logic [NUM_LOCKS-1:0] lock,
  output region_e              rgn
);
  localparam logic [PTR_W-1:0] MEM_END = PTR_W'(MEM_BYTES);
  localparam logic [PTR_W-1:0] CLK_LO  = PTR_W'(CLK_BASE);

  logic [NUM_LOCKS-1:0] hit;

  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_win
    localparam logic [PTR_W-1:0] WLO = PTR_W'(LOCK_BASE + i * LOCK_SPAN);
    localparam logic [PTR_W-1:0] WHI = PTR_W'(LOCK_BASE + (i + 1) * LOCK_SPAN);
    assign hit[i] = lock[i] && (addr >= WLO) && (addr < WHI);
  end

  always_comb begin
    if (addr >= MEM_END)     rgn = RGN_VOID;
    else if (addr >= CLK_LO) rgn = RGN_CLK;
    else if (|hit)           rgn = RGN_BLOCKED;
    else                     rgn = RGN_RAM;
  end
endmodule

// File: rtl/nvram_port_ram.sv
module nvram_port_ram #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    q
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/nvram_port.sv
module nvram_port
  import nvram_port_pkg::*;
#(
  parameter int PTR_W     = 16,
  parameter int MEM_BYTES = 2048,
  parameter int CLK_BASE  = 2040,
  parameter int NUM_LOCKS = 2,
  parameter int LOCK_BASE = 32,
  parameter int LOCK_SPAN = 16,
  parameter int REG_AW    = $clog2(MEM_BYTES - CLK_BASE)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [1:0]           bus_off,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  output logic                 bus_rvalid,
  input  logic [NUM_LOCKS-1:0] lock_set,
  output logic                 reg_wr,
  output logic                 reg_rd,
  output logic [REG_AW-1:0]    reg_addr,
  output logic [7:0]           reg_wdata,
  input  logic [7:0]           reg_rdata
);
  localparam int              AW     = $clog2(MEM_BYTES);
  localparam logic [PTR_W-1:0] CLK_LO = PTR_W'(CLK_BASE);

  logic [PTR_W-1:0]     ptr_q;
  logic [NUM_LOCKS-1:0] lock_q;
  region_e              rgn;
  logic                 wr_req, rd_req, data_wr, data_rd;
  logic                 ram_we;
  logic [7:0]           ram_q;
  logic                 rd_pend_q;
  region_e              rd_kind_q;

  assign wr_req  = bus_sel && bus_we;
  assign rd_req  = bus_sel && !bus_we;
  assign data_wr = wr_req && (bus_off == OFF_DATA);
  assign data_rd = rd_req && (bus_off == OFF_DATA);
  assign ram_we  = data_wr && (rgn == RGN_RAM);

  nvram_port_decode #(
    .PTR_W(PTR_W), .MEM_BYTES(MEM_BYTES), .CLK_BASE(CLK_BASE),
    .NUM_LOCKS(NUM_LOCKS), .LOCK_BASE(LOCK_BASE), .LOCK_SPAN(LOCK_SPAN)
  ) dec_i (
    .addr(ptr_q),
    .lock(lock_q),
    .rgn (rgn)
  );

  nvram_port_ram #(.DEPTH(MEM_BYTES), .AW(AW)) ram_i (
    .clk  (clk),
    .we   (ram_we),
    .addr (AW'(ptr_q)),
    .wdata(bus_wdata),
    .q    (ram_q)
  );

  // pointer, locks and side-port strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q     <= '0;
      lock_q    <= '0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else begin
      lock_q <= lock_q | lock_set;
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      if (wr_req) begin
        case (bus_off)
          OFF_PTR_LO: ptr_q[7:0]       <= bus_wdata;
          OFF_PTR_HI: ptr_q[PTR_W-1:8] <= (PTR_W-8)'(bus_wdata);
          OFF_DATA:   ptr_q            <= '0;
          default:    ;
        endcase
      end
      if ((data_wr || data_rd) && rgn == RGN_CLK) begin
        reg_wr   <= data_wr;
        reg_rd   <= data_rd;
        reg_addr <= REG_AW'(ptr_q - CLK_LO);
        if (data_wr) reg_wdata <= bus_wdata;
      end
    end
  end

  // two-stage read return
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend_q  <= 1'b0;
      rd_kind_q  <= RGN_VOID;
      bus_rvalid <= 1'b0;
      bus_rdata  <= 8'hFF;
    end else begin
      rd_pend_q  <= rd_req;
      rd_kind_q  <= data_rd ? rgn : RGN_VOID;
      bus_rvalid <= rd_pend_q;
      if (rd_pend_q) begin
        case (rd_kind_q)
          RGN_RAM: bus_rdata <= ram_q;
          RGN_CLK: bus_rdata <= reg_rdata;
          default: bus_rdata <= 8'hFF;
        endcase
      end
    end
  end
endmodule

// File: rtl/nvram_port_chk.sv
module nvram_port_chk #(
  parameter int NUM_LOCKS = 2,
  parameter int PTR_W     = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_sel,
  input logic                 bus_we,
  input logic [1:0]           bus_off,
  input logic [7:0]           bus_rdata,
  input logic                 bus_rvalid,
  input logic                 reg_wr,
  input logic                 reg_rd,
  input logic [NUM_LOCKS-1:0] lock_q,
  input logic [PTR_W-1:0]     ptr_q
);
  p_ptr_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_off == 2'd3) |=> (ptr_q == '0));

  p_read_latency_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we) |=> ##1 bus_rvalid);

  p_rvalid_source_r4: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_sel && !bus_we, 2));

  p_side_ff_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we && bus_off != 2'd3) |=> ##1 (bus_rdata == 8'hFF));

  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_off == 2'd2) |=> $stable(ptr_q));

  p_lock0_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    lock_q[0] |=> lock_q[0]);

  p_lock_last_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    lock_q[NUM_LOCKS-1] |=> lock_q[NUM_LOCKS-1]);

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_rd));

  p_wr_strobe_src_r10: assert property (@(posedge clk) disable iff (rst)
    reg_wr |-> $past(bus_sel && bus_we && bus_off == 2'd3));

  p_rd_strobe_src_r10: assert property (@(posedge clk) disable iff (rst)
    reg_rd |-> $past(bus_sel && !bus_we && bus_off == 2'd3));
endmodule

bind nvram_port nvram_port_chk #(.NUM_LOCKS(NUM_LOCKS), .PTR_W(PTR_W)) chk_i (.*);

// File: tb/nvram_port_tb_top.sv
module nvram_port_tb_top;
  localparam int MEM = 2048;
  localparam int CB  = 2040;
  localparam int RAW = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_off = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       bus_rvalid;
  logic [1:0] lock_set = 2'b00;
  logic       reg_wr, reg_rd;
  logic [RAW-1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  always #2 clk = ~clk;

  assign reg_rdata = 8'hC0 | {5'd0, reg_addr};

  nvram_port #(.MEM_BYTES(MEM), .CLK_BASE(CB)) dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_off(bus_off), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .lock_set(lock_set), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  int checks = 0, bad = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference model
  byte unsigned mem_m [int];
  int           ptr_m = 0;
  bit [1:0]     lk_m  = 2'b00;
  bit           e_rv [int];
  byte unsigned e_rd [int];
  string        e_tg [int];
  bit           e_wr [int];
  bit           e_rr [int];
  int           e_ra [int];
  byte unsigned e_wd [int];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic compare_now();
    bit rv, wr, rr;
    rv = e_rv.exists(cyc);
    wr = e_wr.exists(cyc);
    rr = e_rr.exists(cyc);
    chk(bus_rvalid == rv, rv ? e_tg[cyc] : "R4", int'(bus_rvalid), int'(rv));
    if (rv) chk(bus_rdata == e_rd[cyc], e_tg[cyc], int'(bus_rdata), int'(e_rd[cyc]));
    chk(reg_wr == wr, "R10", int'(reg_wr), int'(wr));
    chk(reg_rd == rr, "R10", int'(reg_rd), int'(rr));
    if (wr || rr) chk(int'(reg_addr) == e_ra[cyc], "R10", int'(reg_addr), e_ra[cyc]);
    if (wr) chk(reg_wdata == e_wd[cyc], "R10", int'(reg_wdata), int'(e_wd[cyc]));
  endtask

  function automatic bit sealed(input int a);
    return (lk_m[0] && a >= 32 && a < 48) || (lk_m[1] && a >= 48 && a < 64);
  endfunction

  // one bus cycle: compare, model, drive, advance to next falling edge
  task automatic op(input bit sel, input bit we, input logic [1:0] off,
                    input logic [7:0] wd, input string tag);
    int n, a;
    compare_now();
    n = cyc;
    if (sel && we) begin
      case (off)
        2'd0: ptr_m = (ptr_m & 32'hFF00) | int'(wd);
        2'd1: ptr_m = (ptr_m & 32'h00FF) | (int'(wd) << 8);
        2'd3: begin
          a = ptr_m;
          if (a < MEM && a >= CB) begin
            e_wr[n+1] = 1; e_ra[n+1] = a - CB; e_wd[n+1] = wd;
          end else if (a < CB && !sealed(a)) mem_m[a] = wd;
          ptr_m = 0;
        end
        default: ;
      endcase
    end else if (sel) begin
      e_rv[n+2] = 1; e_tg[n+2] = tag;
      a = ptr_m;
      if (off != 2'd3) e_rd[n+2] = 8'hFF;
      else if (a >= MEM) e_rd[n+2] = 8'hFF;
      else if (a >= CB) begin
        e_rr[n+1] = 1; e_ra[n+1] = a - CB;
        e_rd[n+2] = 8'(8'hC0 | (a - CB));
      end else if (sealed(a)) e_rd[n+2] = 8'hFF;
      else e_rd[n+2] = mem_m[a];
    end
    bus_sel = sel; bus_we = we; bus_off = off; bus_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) op(1'b0, 1'b0, 2'd0, 8'd0, "R4");
  endtask
  task automatic wr(input logic [1:0] off, input logic [7:0] d, input string t);
    op(1'b1, 1'b1, off, d, t);
  endtask
  task automatic rd(input logic [1:0] off, input string t);
    op(1'b1, 1'b0, off, 8'd0, t);
  endtask
  task automatic setp(input int a, input string t);
    wr(2'd0, 8'(a), t);
    wr(2'd1, 8'(a >> 8), t);
  endtask
  task automatic do_lock(input bit [1:0] m);
    compare_now();
    lk_m |= m;
    lock_set = m;
    @(posedge clk);
    @(negedge clk);
    lock_set = 2'b00;
  endtask
  task automatic do_reset();
    rst = 1'b1;
    e_rv.delete(); e_rd.delete(); e_tg.delete(); e_wr.delete();
    e_rr.delete(); e_ra.delete(); e_wd.delete();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    ptr_m = 0; lk_m = 2'b00;
    // R1: reset state at the ports
    chk(bus_rvalid == 1'b0, "R1", int'(bus_rvalid), 0);
    chk(bus_rdata == 8'hFF, "R1", int'(bus_rdata), 8'hFF);
    chk(!reg_wr && !reg_rd, "R1", int'({reg_wr, reg_rd}), 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      bad++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1/R3: pointer starts at zero; write then read back at the cleared pointer
    wr(2'd3, 8'h5A, "R3");
    rd(2'd3, "R1");
    idle(2);
    // R2/R3/R4: pointer halves, auto-clear after write, read keeps pointer
    setp(16'h0123, "R2");
    wr(2'd3, 8'h77, "R3");
    rd(2'd3, "R3");
    setp(16'h0123, "R2");
    rd(2'd3, "R4");
    rd(2'd3, "R4");
    wr(2'd0, 8'h45, "R2");
    wr(2'd3, 8'h66, "R2");
    setp(16'h0145, "R2");
    rd(2'd3, "R2");
    setp(16'h0123, "R2");
    // R5: non-data offsets read all ones
    rd(2'd0, "R5"); rd(2'd1, "R5"); rd(2'd2, "R5");
    // R6: offset 2 write ignored
    wr(2'd2, 8'h99, "R6");
    rd(2'd3, "R6");
    idle(2);
    // R7: lock windows
    setp(16'h0025, "R7"); wr(2'd3, 8'h11, "R7");
    setp(16'h0035, "R7"); wr(2'd3, 8'h22, "R7");
    setp(16'h001F, "R7"); wr(2'd3, 8'h33, "R7");
    setp(16'h0040, "R7"); wr(2'd3, 8'h44, "R7");
    do_lock(2'b01);
    setp(16'h0025, "R7"); wr(2'd3, 8'hEE, "R7");
    setp(16'h0025, "R7"); rd(2'd3, "R7");
    setp(16'h0035, "R7"); rd(2'd3, "R7");
    setp(16'h001F, "R7"); rd(2'd3, "R7");
    do_lock(2'b10);
    setp(16'h0035, "R8"); rd(2'd3, "R8");
    wr(2'd3, 8'hDD, "R7");
    setp(16'h0040, "R7"); wr(2'd3, 8'h55, "R7");
    setp(16'h0040, "R7"); rd(2'd3, "R7");
    setp(16'h0025, "R8"); rd(2'd3, "R8");
    idle(3);
    // R8: reset clears locks, storage survives
    do_reset();
    setp(16'h0025, "R8"); rd(2'd3, "R8");
    setp(16'h0035, "R8"); rd(2'd3, "R8");
    idle(2);
    // R9: void addresses
    setp(16'h0800, "R9"); wr(2'd3, 8'hAB, "R9");
    setp(16'h0800, "R9"); rd(2'd3, "R9");
    setp(16'hFFFF, "R9"); rd(2'd3, "R9");
    rd(2'd3, "R9");
    wr(2'd3, 8'hCD, "R9");
    rd(2'd3, "R9");
    idle(2);
    // R10: clock-register bank through the side port
    setp(CB, "R10"); wr(2'd3, 8'h31, "R10");
    setp(MEM - 1, "R10"); wr(2'd3, 8'h9E, "R10");
    setp(MEM - 1, "R10"); rd(2'd3, "R10");
    rd(2'd3, "R10");
    setp(CB + 3, "R10"); rd(2'd3, "R10");
    setp(CB - 1, "R10"); wr(2'd3, 8'h4B, "R10");
    setp(CB - 1, "R10"); rd(2'd3, "R10");
    idle(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule